// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This block carries out a single-bit read-modify-write on byte-wide memory. A request gives a base value, a signed 16-bit offset, a bit number and an operation code. The unit forms the byte address and reads the byte. It then sets, flips or clears the chosen bit and writes the byte back to the same address. A fourth code only inspects the bit and never writes.

For every operation the unit reports whether the chosen bit was zero before any change. It does this through the zero position of a small flag vector. The other flag positions are passed through untouched. The memory side is a plain synchronous port with a read strobe, a one-cycle write enable, an address and separate read and write data buses. While an operation is in flight the unit shows busy and ignores new requests. A one-cycle done pulse marks completion.

Top module: `bitop_rmw_unit`

## Requirements
- R1: The memory address equals `req_base` plus `req_disp` sign-extended to the address width, with the sum wrapping modulo 2^ADDR_W.
- R2: Each operation reads exactly one byte. `req_bit` selects the bit within that byte, where 0 is the least significant bit and 7 the most significant.
- R3: Operation code 0 sets the selected bit, code 1 inverts it and code 2 clears it. The written byte equals the byte as read, except at the selected bit.
- R4: Operation code 3 only tests the bit. No write strobe is issued for it.
- R5: A write, when issued, goes to the same address as the read of the same operation.
- R6: At done, `flags_out[0]` (the zero flag) is 1 when the selected bit was 0 in the byte as read, and 0 otherwise.
- R7: At done, `flags_out[3:1]` equal `flags_in[3:1]` as sampled when the request was accepted.
- R8: The read strobe comes one cycle after acceptance. The write enable comes two cycles after the read and lasts one cycle. Done is a one-cycle pulse that follows the write by one cycle. For a test, done follows the read by two cycles.
- R9: A request is accepted only while `busy` is low. A request raised while busy causes no memory access.
- R10: After reset the unit is idle: `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `flags_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_base | input | ADDR_W | Base address value |
| req_disp | input | DISP_W | Signed displacement |
| req_bit | input | BIT_W | Bit number within the byte |
| req_op | input | 2 | 0 set, 1 invert, 2 clear, 3 test |
| flags_in | input | FLAG_W | Flag vector to carry, bit 0 is zero flag |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | FLAG_W | Flag vector with updated zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after the strobe |

## Verification
A controller stuck in, or skipping, a state shows at the memory strobes within one or two cycles. The symptoms are a missing or extra write, a write issued for a test, or done arriving off its slot relative to the read. A wrong captured bit number or operation code shows at the next write as more than one flipped bit, or as the wrong bit flipped. A wrong zero flag capture shows in `flags_out` at the done pulse of the same operation. A bad address register shows on `mem_addr` during the read strobe itself.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    BOP_SET = 2'd0,
    BOP_INV = 2'd1,
    BOP_CLR = 2'd2,
    BOP_TST = 2'd3
  } bop_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } bst_e;

  localparam int ZF_POS = 0;
endpackage

// File: rtl/bitop_rst_sync.sv
module bitop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bitop_addr_gen.sv
module bitop_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  assign eff_addr = base + disp_ext;
endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [BIT_W-1:0]  bit_sel,
  input  bop_e              op,
  output logic [DATA_W-1:0] wdata,
  output logic              was_zero
);
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic hit;
      assign hit = (bit_sel == BIT_W'(i));
      always_comb begin
        if (!hit) begin
          wdata[i] = rdata[i];
        end else begin
          unique case (op)
            BOP_SET: wdata[i] = 1'b1;
            BOP_INV: wdata[i] = ~rdata[i];
            BOP_CLR: wdata[i] = 1'b0;
            default: wdata[i] = rdata[i];
          endcase
        end
      end
    end
  endgenerate

  assign was_zero = ~rdata[bit_sel];
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic is_test,
  output logic accept,
  output logic rd_stb,
  output logic capture,
  output logic wr_stb,
  output logic done,
  output logic busy
);
  bst_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_READ;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  state_d = is_test ? ST_DONE : ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign rd_stb  = (state_q == ST_READ);
  assign capture = (state_q == ST_WAIT);
  assign wr_stb  = (state_q == ST_WRITE);
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/bitop_rmw_unit.sv
module bitop_rmw_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [BIT_W-1:0]  req_bit,
  input  logic [1:0]        req_op,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic [FLAG_W-1:0] flags_out,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int HI_W = FLAG_W - 1;

  logic              rst_int_n;
  logic              accept, capture;
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  bop_e              op_q;
  logic [HI_W-1:0]   flags_hi_q;
  logic [FLAG_W-1:0] flags_q;
  logic [DATA_W-1:0] wdata_q, wdata_c;
  logic              was_zero;

  bitop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bitop_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .base     (req_base),
    .disp     (req_disp),
    .eff_addr (ea)
  );

  bitop_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .is_test   (op_q == BOP_TST),
    .accept    (accept),
    .rd_stb    (mem_rd),
    .capture   (capture),
    .wr_stb    (mem_wr),
    .done      (done),
    .busy      (busy)
  );

  bitop_modify #(.DATA_W(DATA_W)) u_mod (
    .rdata    (mem_rdata),
    .bit_sel  (bit_q),
    .op       (op_q),
    .wdata    (wdata_c),
    .was_zero (was_zero)
  );

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q     <= '0;
      bit_q      <= '0;
      op_q       <= BOP_SET;
      flags_hi_q <= '0;
    end else if (accept) begin
      addr_q     <= ea;
      bit_q      <= req_bit;
      op_q       <= bop_e'(req_op);
      flags_hi_q <= flags_in[FLAG_W-1:1];
    end
  end

  // read data capture, enabled in the data-valid cycle
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wdata_q <= '0;
      flags_q <= '0;
    end else if (capture) begin
      wdata_q <= wdata_c;
      flags_q <= {flags_hi_q, was_zero};
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign flags_out = flags_q;
endmodule

// File: rtl/bitop_rmw_unit_chk.sv
module bitop_rmw_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);
  assert_rw_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_single_bit_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

  assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  assert_same_address_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr, 2)));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_wr) || $past(mem_rd, 2)));

  assert_read_from_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(req_valid && !busy));
endmodule

bind bitop_rmw_unit bitop_rmw_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/bitop_rmw_unit_tb.sv
`timescale 1ns/1ps
module bitop_rmw_unit_tb;
  localparam int ADDR_W = 32;
  localparam int DISP_W = 16;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_base;
  logic [DISP_W-1:0] req_disp;
  logic [2:0]        req_bit;
  logic [1:0]        req_op;
  logic [FLAG_W-1:0] flags_in;
  logic              busy, done, mem_rd, mem_wr;
  logic [FLAG_W-1:0] flags_out;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bitop_rmw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_disp(req_disp), .req_bit(req_bit), .req_op(req_op), .flags_in(flags_in),
    .busy(busy), .done(done), .flags_out(flags_out), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // byte memory model and port monitor
  logic [7:0] mem [256];
  int cyc = 0, acc_cyc = 0, rd_cyc = 0, wr_cyc = 0, done_cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[7:0]];
      rd_cyc <= cyc; rd_addr <= mem_addr; rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cyc <= cyc; wr_addr <= mem_addr; wr_data <= mem_wdata; wr_cnt <= wr_cnt + 1;
    end
    if (req_valid && !busy && rst_n) acc_cyc <= cyc;
    if (done) done_cyc <= cyc;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) break;
    end
    check(done, "R8 done timeout", done, 1);
    @(posedge clk); #1;
  endtask

  // run one operation and check every observable effect
  task automatic run_op(input logic [31:0] base, input logic [15:0] disp,
                        input logic [2:0] b, input logic [1:0] op, input logic [3:0] fl);
    logic [31:0] ea;
    logic [7:0]  orig, expb;
    int rd0, wr0;
    ea   = base + {{16{disp[15]}}, disp};
    orig = mem[ea[7:0]];
    expb = orig;
    case (op)
      2'd0: expb[b] = 1'b1;
      2'd1: expb[b] = ~orig[b];
      2'd2: expb[b] = 1'b0;
      default: expb = orig;
    endcase
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1; req_base = base; req_disp = disp; req_bit = b; req_op = op; flags_in = fl;
    @(negedge clk);
    req_valid = 0;
    wait_done();
    check(rd_addr == ea, "R1 address", rd_addr, ea);
    check(rd_cnt - rd0 == 1, "R2 one read", rd_cnt - rd0, 1);
    check(rd_cyc == acc_cyc + 1, "R8 read slot", rd_cyc - acc_cyc, 1);
    check(flags_out[0] == ~orig[b], "R6 zero flag", flags_out[0], ~orig[b]);
    check(flags_out[3:1] == fl[3:1], "R7 other flags", flags_out[3:1], fl[3:1]);
    if (op == 2'd3) begin
      check(wr_cnt == wr0, "R4 no write on test", wr_cnt - wr0, 0);
      check(done_cyc == rd_cyc + 2, "R8 test done slot", done_cyc - rd_cyc, 2);
    end else begin
      check(wr_cnt - wr0 == 1, "R3 one write", wr_cnt - wr0, 1);
      check(wr_addr == ea, "R5 write address", wr_addr, ea);
      check(wr_data == expb, "R3 written byte", wr_data, expb);
      check(wr_cyc == rd_cyc + 2, "R8 write slot", wr_cyc - rd_cyc, 2);
      check(done_cyc == wr_cyc + 1, "R8 done slot", done_cyc - wr_cyc, 1);
    end
    check(mem[ea[7:0]] == expb, "R3 memory byte", mem[ea[7:0]], expb);
  endtask

  task automatic t_reset();
    rst_n = 0; req_valid = 0; req_base = '0; req_disp = '0; req_bit = '0;
    req_op = '0; flags_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !mem_rd && !mem_wr, "R10 idle outputs",
          {busy, done, mem_rd, mem_wr}, 0);
    check(flags_out == 0, "R10 flags reset", flags_out, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_set();
    mem[8'h24] = 8'h00;
    run_op(32'h0000_0020, 16'h0004, 3'd5, 2'd0, 4'b1010);   // R3 set from 0, R6 Z=1
    run_op(32'h0000_0020, 16'h0004, 3'd5, 2'd0, 4'b0000);   // R3 set already set, Z=0
  endtask

  task automatic t_invert();
    mem[8'h40] = 8'hA5;
    run_op(32'h0000_0040, 16'h0000, 3'd0, 2'd1, 4'b0110);   // R3 invert lsb 1->0
    run_op(32'h0000_0040, 16'h0000, 3'd7, 2'd1, 4'b1000);   // R3 invert msb 1->0
    run_op(32'h0000_0040, 16'h0000, 3'd7, 2'd1, 4'b0100);   // R3 invert msb 0->1
  endtask

  task automatic t_clear();
    mem[8'h7F] = 8'hFF;
    run_op(32'h0000_007E, 16'h0001, 3'd3, 2'd2, 4'b1110);   // R3 clear
  endtask

  task automatic t_test();
    mem[8'h10] = 8'h08;
    run_op(32'h0000_0010, 16'h0000, 3'd3, 2'd3, 4'b0010);   // R4 test set bit
    run_op(32'h0000_0010, 16'h0000, 3'd2, 2'd3, 4'b1100);   // R4 test clear bit
  endtask

  task automatic t_negdisp();
    mem[8'hF0] = 8'h3C;
    run_op(32'h0001_0000, 16'hFFF0, 3'd1, 2'd0, 4'b0000);   // R1 negative offset, borrow
    mem[8'h05] = 8'h00;
    run_op(32'hFFFF_FFFF, 16'h0006, 3'd6, 2'd1, 4'b1110);   // R1 wraps past top
  endtask

  task automatic t_busy_ignore();
    int rd0;
    mem[8'h50] = 8'h00;
    mem[8'h60] = 8'h00;
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1; req_base = 32'h50; req_disp = 0; req_bit = 3'd2; req_op = 2'd0; flags_in = 0;
    @(negedge clk);
    req_base = 32'h60; req_bit = 3'd4;                       // R9 held while busy
    for (int i = 0; i < 20; i++) begin
      if (done) break;
      @(negedge clk);
    end
    req_valid = 0;
    @(posedge clk); #1;
    repeat (2) @(negedge clk);
    check(rd_cnt - rd0 == 1, "R9 single access", rd_cnt - rd0, 1);
    check(mem[8'h60] == 8'h00, "R9 second byte untouched", mem[8'h60], 0);
    check(mem[8'h50] == 8'h04, "R9 first op done", mem[8'h50], 8'h04);
    check(!busy, "R9 idle after", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem_rdata = 8'h00;
    t_reset();
    t_set();
    t_invert();
    t_clear();
    t_test();
    t_negdisp();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule